// File: doc/BRIEF.md
# Four-Phase Two-Stage Instruction Front End

This block is the instruction front end of a small microcontroller core. A free-running sequencer splits every instruction cycle into four quarter phases, Q1 to Q4, one input clock each. The front end runs two stages at once. While the instruction in the instruction register executes, the next word is fetched from a byte-addressed program memory. The memory is outside the block and returns the word combinationally for the address on `pm_addr`.

Only control flow is decoded: no-op, jump, call and return. Every other opcode counts as a plain single-cycle operation. For those it raises a data-memory read strobe in Q2 and a write strobe in Q4. When a jump, call or return redirects the program counter, the word fetched during that execute cycle is replaced by a no-op. The target is fetched in the following cycle. Calls push the address of the following instruction onto an internal return stack, and returns pop it.

The sequencer is a four-state machine. The states are Q1, Q2, Q3 and Q4, and the transitions are Q1→Q2, Q2→Q3, Q3→Q4 and Q4→Q1 on every clock. Reset forces the state to Q1 from any state. The executing instruction falls into one of four flow classes: SEQ, JUMP, CALL or RET. The class decides the next fetch address at the Q4→Q1 transition.

Top module: `qpipe_frontend`

## Requirements
- R1: `phase` reads 0,1,2,3 for Q1,Q2,Q3,Q4, advances by one each clock, wraps from 3 to 0, and is 0 while reset is held.
- R2: During synchronous reset `pm_addr` is 0 and `ir` is 0x0000, the no-op. The first instruction cycle after release raises neither data strobe.
- R3: `pm_addr` changes only at the start of Q1 and holds for all four phases. Without a redirect it advances by 2 per instruction cycle.
- R4: From Q1 of each instruction cycle, `ir` holds the word that the memory returned for the previous cycle's fetch address, unless that word was flushed.
- R5: An executing opcode `ir[15:12]` outside {0x0, 0xC, 0xD, 0xE} raises `dm_rd` for exactly phase Q2 and `dm_wr` for exactly phase Q4. A no-op, a flushed slot or a control-flow instruction raises neither.
- R6: Jump (opcode 0xE) makes the next fetch address `{ir[10:0],0}`, and `ir` becomes 0x0000 in the next cycle instead of the prefetched word.
- R7: Call (opcode 0xD) jumps like R6 and pushes the byte address of the instruction after the call.
- R8: Return (opcode 0xC) makes the next fetch address the most recently pushed address, pops it, and flushes the prefetched word.
- R9: The return stack is last-in first-out and holds 8 addresses, so 8 nested calls return in reverse order.
- R10: A call with 8 entries stored raises `stk_ovf` during its Q4 and discards the new address, leaving the 8 stored entries intact. The jump still happens.
- R11: A return with the stack empty raises `stk_unf` during its Q4, redirects the fetch to address 0, and flushes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one clock per quarter cycle |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 12 | Byte fetch address to program memory, bit 0 always 0 |
| pm_data | input | 16 | Instruction word returned for `pm_addr` |
| phase | output | 2 | Current quarter phase, 0 to 3 for Q1 to Q4 |
| ir | output | 16 | Instruction register, the instruction now executing |
| dm_rd | output | 1 | Data-memory operand read strobe (Q2) |
| dm_wr | output | 1 | Data-memory destination write strobe (Q4) |
| stk_ovf | output | 1 | Return-stack push while full (Q4 of the call) |
| stk_unf | output | 1 | Return-stack pop while empty (Q4 of the return) |

## Verification
A phase counter that slips shifts the data strobes out of Q2 and Q4, and it moves the `pm_addr` update away from the Q1 boundary, so the fault is visible within one instruction cycle. A missed flush shows one cycle after the redirect: `ir` holds a live word instead of 0x0000, and that word raises data strobes. A corrupted return stack or stack pointer shows only when a return executes. The fetch address two cycles later is then wrong, so the nested-call test has to unwind all the way to the underflow to expose every entry.

// File: rtl/qpipe_pkg.sv
package qpipe_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        CF_SEQ,
        CF_JUMP,
        CF_CALL,
        CF_RET
    } flow_t;

    localparam int unsigned OPC_W    = 4;
    localparam logic [3:0]  OPC_NOP  = 4'h0;
    localparam logic [3:0]  OPC_RET  = 4'hC;
    localparam logic [3:0]  OPC_CALL = 4'hD;
    localparam logic [3:0]  OPC_JUMP = 4'hE;

endpackage

// File: rtl/qpipe_phase_seq.sv
module qpipe_phase_seq
    import qpipe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   cycle_end
);

    phase_t state_q;
    phase_t state_d;

    always_comb begin
        unique case (state_q)
            PH_Q1:   state_d = PH_Q2;
            PH_Q2:   state_d = PH_Q3;
            PH_Q3:   state_d = PH_Q4;
            PH_Q4:   state_d = PH_Q1;
            default: state_d = PH_Q1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_Q1;
        else     state_q <= state_d;
    end

    always_comb begin
        phase     = state_q;
        cycle_end = (state_q == PH_Q4);
    end

    // R1: each clock moves the phase forward by exactly one, wrapping
    p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_q == phase_t'($past(state_q) + 2'd1));

endmodule

// File: rtl/qpipe_ret_stack.sv
module qpipe_ret_stack #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic              ovf,
    output logic              unf
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned SP_W  = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    logic [ADDR_W-1:0] slots [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic              full;
    logic              empty;

    always_comb begin
        full     = (sp_q == SP_FULL);
        empty    = (sp_q == '0);
        ovf      = push && full;
        unf      = pop && empty;
        top_addr = slots[IDX_W'(sp_q - SP_W'(1))];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push && !full) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop && !empty) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) slots[IDX_W'(sp_q)] <= push_addr;
    end

    // R9: the pointer never passes the depth
    p_sp_bound_r9: assert property (@(posedge clk) disable iff (rst)
        sp_q <= SP_FULL);

    // R9: an accepted push grows the stack by one entry
    p_push_grow_r9: assert property (@(posedge clk) disable iff (rst)
        (push && !ovf) |=> sp_q == $past(sp_q) + SP_W'(1));

    // R10: a push into a full stack leaves the pointer alone
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        ovf |=> sp_q == $past(sp_q));

    // R11: a pop from an empty stack leaves the pointer alone
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        unf |=> sp_q == $past(sp_q));

endmodule

// File: rtl/qpipe_frontend.sv
module qpipe_frontend
    import qpipe_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned INSTR_W     = 16,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  pm_addr,
    input  logic [INSTR_W-1:0] pm_data,
    output logic [1:0]         phase,
    output logic [INSTR_W-1:0] ir,
    output logic               dm_rd,
    output logic               dm_wr,
    output logic               stk_ovf,
    output logic               stk_unf
);

    localparam int unsigned TGT_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0]  STEP     = ADDR_W'(2);
    localparam logic [INSTR_W-1:0] NOP_WORD = '0;

    phase_t             ph;
    logic               cyc_end;
    logic [ADDR_W-1:0]  pc_q;
    logic [ADDR_W-1:0]  pc_d;
    logic [INSTR_W-1:0] ir_q;
    logic [OPC_W-1:0]   opcode;
    logic [ADDR_W-1:0]  target;
    logic [ADDR_W-1:0]  ret_addr;
    flow_t              flow;
    logic               data_op;
    logic               do_push;
    logic               do_pop;
    logic               ovf;
    logic               unf;

    qpipe_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .phase     (ph),
        .cycle_end (cyc_end)
    );

    // decode of the executing instruction
    always_comb begin
        opcode = ir_q[INSTR_W-1 -: OPC_W];
        target = {ir_q[TGT_W-1:0], 1'b0};
        unique case (opcode)
            OPC_JUMP: flow = CF_JUMP;
            OPC_CALL: flow = CF_CALL;
            OPC_RET:  flow = CF_RET;
            default:  flow = CF_SEQ;
        endcase
        data_op = (flow == CF_SEQ) && (opcode != OPC_NOP);
        do_push = cyc_end && (flow == CF_CALL);
        do_pop  = cyc_end && (flow == CF_RET);
    end

    qpipe_ret_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (pc_q),
        .top_addr  (ret_addr),
        .ovf       (ovf),
        .unf       (unf)
    );

    // next fetch address, taken at the Q4 -> Q1 transition
    always_comb begin
        unique case (flow)
            CF_SEQ:  pc_d = pc_q + STEP;
            CF_JUMP: pc_d = target;
            CF_CALL: pc_d = target;
            CF_RET:  pc_d = unf ? '0 : ret_addr;
            default: pc_d = pc_q + STEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= NOP_WORD;
        end else if (cyc_end) begin
            pc_q <= pc_d;
            ir_q <= (flow == CF_SEQ) ? pm_data : NOP_WORD;
        end
    end

    // output process: phase-qualified strobes
    always_comb begin
        pm_addr = pc_q;
        phase   = ph;
        ir      = ir_q;
        stk_ovf = ovf;
        stk_unf = unf;
        dm_rd   = 1'b0;
        dm_wr   = 1'b0;
        unique case (ph)
            PH_Q1:   ;
            PH_Q2:   dm_rd = data_op;
            PH_Q3:   ;
            PH_Q4:   dm_wr = data_op;
            default: ;
        endcase
    end

    // R3: the fetch address only moves at the start of Q1
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> $stable(pm_addr));

    // R3: a sequential instruction cycle steps the fetch address by two
    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && flow == CF_SEQ) |=> pm_addr == $past(pm_addr) + STEP);

    // R5: every write strobe follows a read strobe of the same instruction
    p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> $past(dm_rd, 2));

    // R6: a redirect leaves a no-op in the instruction register
    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && flow != CF_SEQ) |=> ir == NOP_WORD);

endmodule

// File: tb/tb_qpipe_frontend.sv
module tb_qpipe_frontend;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] pm_addr;
    logic [15:0] pm_data;
    logic [1:0]  phase;
    logic [15:0] ir;
    logic        dm_rd;
    logic        dm_wr;
    logic        stk_ovf;
    logic        stk_unf;

    logic [15:0] prog [2048];
    int checks = 0;
    int errors = 0;
    int cur    = 0;

    always #2.5 clk = ~clk;

    assign pm_data = prog[pm_addr[11:1]];

    qpipe_frontend dut (
        .clk     (clk),
        .rst     (rst),
        .pm_addr (pm_addr),
        .pm_data (pm_data),
        .phase   (phase),
        .ir      (ir),
        .dm_rd   (dm_rd),
        .dm_wr   (dm_wr),
        .stk_ovf (stk_ovf),
        .stk_unf (stk_unf)
    );

    // per instruction cycle of program A: {fetch address, ir, data op}
    localparam logic [28:0] TRACE [13] = '{
        {12'h000, 16'h0000, 1'b0},
        {12'h002, 16'h1234, 1'b1},
        {12'h004, 16'h0000, 1'b0},
        {12'h006, 16'hE005, 1'b0},
        {12'h00A, 16'h0000, 1'b0},
        {12'h00C, 16'hD010, 1'b0},
        {12'h020, 16'h0000, 1'b0},
        {12'h022, 16'h5555, 1'b1},
        {12'h024, 16'hC000, 1'b0},
        {12'h00C, 16'h0000, 1'b0},
        {12'h00E, 16'h4444, 1'b1},
        {12'h010, 16'hE040, 1'b0},
        {12'h080, 16'h0000, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic adv_to(input int k, input int q);
        int target;
        target = 4 * k + q;
        while (cur < target) begin
            @(negedge clk);
            cur++;
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 2048; i++) prog[i] = 16'h0000;
    endtask

    task automatic do_reset(input bit check_it);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (check_it) begin
            check("R1", "phase in reset", 32'(phase), 32'd0);
            check("R2", "pm_addr in reset", 32'(pm_addr), 32'h000);
            check("R2", "ir in reset", 32'(ir), 32'h0000);
        end
        rst = 1'b0;
        cur = 0;
    endtask

    initial begin
        #100us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // program A: sequential, jump, call, return
        clear_prog();
        prog[0]  = 16'h1234;
        prog[1]  = 16'h0000;
        prog[2]  = 16'hE005;
        prog[3]  = 16'h2222;
        prog[4]  = 16'h3333;
        prog[5]  = 16'hD010;
        prog[6]  = 16'h4444;
        prog[7]  = 16'hE040;
        prog[16] = 16'h5555;
        prog[17] = 16'hC000;
        prog[18] = 16'h6666;
        do_reset(1'b1);

        for (int k = 0; k < 13; k++) begin
            string tag;
            tag = (k == 4) ? "R6" : (k == 6) ? "R7" : (k == 9) ? "R8" : "R3";
            adv_to(k, 1);
            check("R1", "phase Q2", 32'(phase), 32'd1);
            check(tag, "pm_addr", 32'(pm_addr), 32'(TRACE[k][28:17]));
            check((k == 4 || k == 6 || k == 9) ? tag : "R4", "ir",
                  32'(ir), 32'(TRACE[k][16:1]));
            check((k == 0) ? "R2" : "R5", "dm_rd in Q2", 32'(dm_rd), 32'(TRACE[k][0]));
            check("R5", "dm_wr off in Q2", 32'(dm_wr), 32'd0);
            adv_to(k, 3);
            check("R1", "phase Q4", 32'(phase), 32'd3);
            check("R3", "pm_addr held", 32'(pm_addr), 32'(TRACE[k][28:17]));
            check("R5", "dm_wr in Q4", 32'(dm_wr), 32'(TRACE[k][0]));
            check("R5", "dm_rd off in Q4", 32'(dm_rd), 32'd0);
        end

        // program B: nine nested calls, then unwind into underflow
        clear_prog();
        for (int j = 0; j < 9; j++) prog[2*j] = 16'hD000 | 16'(2*j + 2);
        for (int j = 0; j < 9; j++) prog[2*j + 1] = 16'hC000;
        prog[18] = 16'hC000;
        do_reset(1'b0);

        adv_to(15, 3);
        check("R10", "no overflow on 8th push", 32'(stk_ovf), 32'd0);
        adv_to(17, 3);
        check("R10", "overflow on 9th push", 32'(stk_ovf), 32'd1);
        adv_to(18, 1);
        check("R10", "call still jumps", 32'(pm_addr), 32'h024);
        check("R6", "flushed after call", 32'(ir), 32'h0000);
        adv_to(20, 1);
        check("R10", "top entry intact", 32'(pm_addr), 32'h01E);
        adv_to(22, 1);
        check("R9", "second pop", 32'(pm_addr), 32'h01A);
        adv_to(33, 3);
        check("R11", "no underflow on 8th pop", 32'(stk_unf), 32'd0);
        adv_to(34, 1);
        check("R9", "bottom entry", 32'(pm_addr), 32'h002);
        adv_to(35, 1);
        check("R8", "return executing", 32'(ir), 32'hC000);
        adv_to(35, 3);
        check("R11", "underflow flag", 32'(stk_unf), 32'd1);
        adv_to(36, 1);
        check("R11", "underflow redirect", 32'(pm_addr), 32'h000);
        check("R11", "underflow flush", 32'(ir), 32'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule